// File: doc/BRIEF.md
# SCSI Initiator Register Front-End

This block is the host-facing register file of a SCSI initiator controller. A host bus makes single-byte accesses. Each access selects one of sixteen byte registers through address bits [5:2], so the registers sit four bytes apart. Each register has two copies. A write always updates the write copy. A read always returns the read copy, and only a few writes also change it. Index 2 is the data port of a 16-byte transfer FIFO. Index 3 takes commands. Index 4 holds status bits and index 5 holds interrupt cause bits.

A command can flush the FIFO, reset the whole block, reset the SCSI bus or accept a message. Bus-reset and message-accepted commands raise a request toward the target-side logic, which stands in for the SCSI bus. That request stays high until the target logic acknowledges it. A single interrupt line goes to the host. The host services the interrupt by reading the interrupt register. That read clears the status bits and drops the line.

Top module: `scsi_host_regs`

## Requirements
- R1: After reset, every readable index returns 0x00 except index 14, which returns 0x04. The FIFO level at index 7 is 0, and irq_o and tgt_req_o are low.
- R2: The register index is host_addr[5:2]. Address bits [1:0] are ignored on both reads and writes.
- R3: Writes to indices 0 and 1 are read back unchanged. A write to index 10 reads back ANDed with 0x15. A write to index 3 is echoed in its read copy. Writes to indices 8 and 9 leave their read copies at 0.
- R4: A write to index 2 pushes a byte and a read of index 2 pops one, in first-in first-out order. Index 7 returns the number of bytes held.
- R5: A push into a full FIFO (16 bytes) is dropped and sets status bit 0 (index 4). A pop from an empty FIFO returns 0x00 and changes nothing.
- R6: A pop that leaves the FIFO empty sets status bit 4, the terminal-count bit.
- R7: Command 0x01 empties the FIFO and loads index 5 with 0x08.
- R8: Command 0x03 loads index 5 with 0x80. If bit 6 of write register 8 is clear, it also raises irq_o and sets status bit 7. If that bit is set, both stay unchanged.
- R9: Command 0x12 loads index 5 with 0x20.
- R10: A read of index 5 returns its value, clears every status bit except bit 4, and lowers irq_o.
- R11: Command 0x02 returns all read copies, write copies, the FIFO, irq_o and tgt_req_o to the state given in R1.
- R12: Command 0x00 and every code not listed in R7 to R11 change nothing except the echo in index 3.
- R13: Commands 0x03 and 0x12 raise tgt_req_o, with tgt_op_o set to 0 for bus reset and 1 for message accepted. The request holds until a cycle with tgt_ack_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Byte address; bits [5:2] select the register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register, valid while host_sel is high |
| irq_o | output | 1 | Interrupt to the host |
| tgt_req_o | output | 1 | Request to the target-side logic |
| tgt_op_o | output | 1 | Requested operation: 0 bus reset, 1 message accepted |
| tgt_ack_i | input | 1 | Acknowledge from the target-side logic |

## Verification
The index-10 mask is tested with all 256 data values. Indices 0 and 1 are tested with spread values at every low-address offset, which separates a correct index decode from one that uses address bits [1:0]. The FIFO is run with a short burst, with an overfilled burst of seventeen bytes and with pops while empty, each burst using a distinct arithmetic byte pattern. These runs separate ordering errors, wrong drop behaviour and a wrong terminal-count point. The bus-reset command is issued with its mask bit clear, then with it set, then again after a chip reset has cleared the mask. Together these tell apart the masked interrupt, the unmasked interrupt and the way a chip reset clears the write copies. Unknown codes and the no-operation code are sent after the FIFO and the interrupt register already hold known state, so that any side effect shows up at the ports.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

  localparam int unsigned REG_CNT = 16;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned BYTE_W  = 8;

  localparam logic [IDX_W-1:0] IDX_CNT_LO = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CNT_HI = 4'd1;
  localparam logic [IDX_W-1:0] IDX_FIFO   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] IDX_STAT   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_INT    = 4'd5;
  localparam logic [IDX_W-1:0] IDX_FLEVEL = 4'd7;
  localparam logic [IDX_W-1:0] IDX_CFG    = 4'd8;
  localparam logic [IDX_W-1:0] IDX_OPT    = 4'd10;
  localparam logic [IDX_W-1:0] IDX_REV    = 4'd14;

  localparam logic [BYTE_W-1:0] REV_ID   = 8'h04;
  localparam logic [BYTE_W-1:0] OPT_MASK = 8'h15;

  localparam int unsigned ST_OVF = 0;
  localparam int unsigned ST_TC  = 4;
  localparam int unsigned ST_INT = 7;

  localparam int unsigned CFG_RSTINT_OFF = 6;

  localparam logic [BYTE_W-1:0] INT_BUSRST = 8'h80;
  localparam logic [BYTE_W-1:0] INT_DISC   = 8'h20;
  localparam logic [BYTE_W-1:0] INT_DONE   = 8'h08;

  localparam logic [BYTE_W-1:0] CODE_NOP     = 8'h00;
  localparam logic [BYTE_W-1:0] CODE_FLUSH   = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_CHIPRST = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_BUSRST  = 8'h03;
  localparam logic [BYTE_W-1:0] CODE_MSGACC  = 8'h12;

  typedef enum logic [2:0] {
    OP_NONE, OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_MSGACC
  } cmd_op_e;

  typedef enum logic {
    TGT_BUSRST = 1'b0,
    TGT_MSGACC = 1'b1
  } tgt_op_e;

endpackage

// File: rtl/scsi_rst_sync.sv
module scsi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_regs_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output cmd_op_e           op
);
  always_comb begin
    unique case (code)
      CODE_NOP:     op = OP_NOP;
      CODE_FLUSH:   op = OP_FLUSH;
      CODE_CHIPRST: op = OP_CHIPRST;
      CODE_BUSRST:  op = OP_BUSRST;
      CODE_MSGACC:  op = OP_MSGACC;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/scsi_xfer_fifo.sv
module scsi_xfer_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop, empty;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) wptr_d = wrap_inc(wptr_q);
      if (do_pop)  rptr_d = wrap_inc(rptr_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= din;
  end

  assign head  = empty ? '0 : mem_q[rptr_q];
  assign count = cnt_q;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (push && !pop && !clr && full) |=> full);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (pop && !push && !clr && empty) |=> (cnt_q == '0));
  p_clear_r7: assert property (@(posedge clk) disable iff (!srst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_regs_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ADDR_W     = 6,
  localparam int unsigned IDX_LSB   = 2,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq_o,
  output logic              tgt_req_o,
  output logic              tgt_op_o,
  input  logic              tgt_ack_i
);
  logic srst_n;

  scsi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  logic [IDX_W-1:0]  idx;
  logic              rd_acc, wr_acc;
  cmd_op_e           cmd_op;

  assign idx    = host_addr[IDX_LSB +: IDX_W];
  assign rd_acc = host_sel && !host_wr;
  assign wr_acc = host_sel && host_wr;

  scsi_cmd_decode u_cmd_decode (
    .code (host_wdata),
    .op   (cmd_op)
  );

  logic [BYTE_W-1:0] rimg_q [REG_CNT];
  logic [BYTE_W-1:0] rimg_d [REG_CNT];
  logic [BYTE_W-1:0] wimg_q [REG_CNT];
  logic [BYTE_W-1:0] wimg_d [REG_CNT];
  logic              irq_q, irq_d;
  logic              req_q, req_d;
  tgt_op_e           op_q, op_d;

  logic              fifo_push, fifo_pop, fifo_clr, chip_rst;
  logic              fifo_full, fifo_drop, fifo_drained;
  logic [BYTE_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;

  assign fifo_push    = wr_acc && (idx == IDX_FIFO);
  assign fifo_pop     = rd_acc && (idx == IDX_FIFO);
  assign chip_rst     = wr_acc && (idx == IDX_CMD) && (cmd_op == OP_CHIPRST);
  assign fifo_clr     = wr_acc && (idx == IDX_CMD) &&
                        ((cmd_op == OP_FLUSH) || (cmd_op == OP_CHIPRST));
  assign fifo_drop    = fifo_push && fifo_full;
  assign fifo_drained = fifo_pop && (fifo_cnt == CNT_W'(1));

  scsi_xfer_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk    (clk),
    .srst_n (srst_n),
    .push   (fifo_push),
    .pop    (fifo_pop),
    .clr    (fifo_clr),
    .din    (host_wdata),
    .head   (fifo_head),
    .count  (fifo_cnt),
    .full   (fifo_full)
  );

  function automatic logic [BYTE_W-1:0] rimg_init(input int unsigned i);
    return (i == int'(IDX_REV)) ? REV_ID : '0;
  endfunction

  // next-state logic
  always_comb begin
    for (int i = 0; i < REG_CNT; i++) begin
      rimg_d[i] = rimg_q[i];
      wimg_d[i] = wimg_q[i];
    end
    irq_d = irq_q;
    req_d = req_q;
    op_d  = op_q;

    if (req_q && tgt_ack_i) req_d = 1'b0;

    if (wr_acc) begin
      wimg_d[idx] = host_wdata;
      unique case (idx)
        IDX_CNT_LO, IDX_CNT_HI: rimg_d[idx] = host_wdata;
        IDX_OPT:                rimg_d[idx] = host_wdata & OPT_MASK;
        IDX_CMD: begin
          rimg_d[IDX_CMD] = host_wdata;
          unique case (cmd_op)
            OP_FLUSH:  rimg_d[IDX_INT] = INT_DONE;
            OP_MSGACC: begin
              rimg_d[IDX_INT] = INT_DISC;
              req_d = 1'b1;
              op_d  = TGT_MSGACC;
            end
            OP_BUSRST: begin
              rimg_d[IDX_INT] = INT_BUSRST;
              req_d = 1'b1;
              op_d  = TGT_BUSRST;
              if (!wimg_q[IDX_CFG][CFG_RSTINT_OFF]) begin
                irq_d = 1'b1;
                rimg_d[IDX_STAT][ST_INT] = 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end else if (rd_acc && (idx == IDX_INT)) begin
      rimg_d[IDX_STAT] = rimg_q[IDX_STAT] & (BYTE_W'(1) << ST_TC);
      irq_d = 1'b0;
    end

    if (fifo_drop)    rimg_d[IDX_STAT][ST_OVF] = 1'b1;
    if (fifo_drained) rimg_d[IDX_STAT][ST_TC]  = 1'b1;

    if (chip_rst) begin
      for (int i = 0; i < REG_CNT; i++) begin
        rimg_d[i] = rimg_init(i);
        wimg_d[i] = '0;
      end
      irq_d = 1'b0;
      req_d = 1'b0;
      op_d  = TGT_BUSRST;
    end
  end

  // register images, one flop group per index
  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        rimg_q[g] <= rimg_init(g);
        wimg_q[g] <= '0;
      end else begin
        rimg_q[g] <= rimg_d[g];
        wimg_q[g] <= wimg_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
      op_q  <= TGT_BUSRST;
    end else begin
      irq_q <= irq_d;
      req_q <= req_d;
      op_q  <= op_d;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_FIFO:   host_rdata = fifo_head;
      IDX_FLEVEL: host_rdata = BYTE_W'(fifo_cnt);
      default:    host_rdata = rimg_q[idx];
    endcase
  end

  assign irq_o     = irq_q;
  assign tgt_req_o = req_q;
  assign tgt_op_o  = op_q;

  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_acc && idx == IDX_INT) |=> !irq_o);
  p_tc_kept_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_acc && idx == IDX_INT) |=>
      (((rimg_q[IDX_STAT] & ~(BYTE_W'(1) << ST_TC)) == '0) &&
       (rimg_q[IDX_STAT][ST_TC] == $past(rimg_q[IDX_STAT][ST_TC]))));
  p_rstint_masked_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_acc && idx == IDX_CMD && cmd_op == OP_BUSRST &&
     wimg_q[IDX_CFG][CFG_RSTINT_OFF] && !irq_o) |=> !irq_o);
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!srst_n)
    (tgt_req_o && !tgt_ack_i && !chip_rst) |=> tgt_req_o);
  p_rev_after_reset_r11: assert property (@(posedge clk) disable iff (!srst_n)
    chip_rst |=> (rimg_q[IDX_REV] == REV_ID && fifo_cnt == '0 && !irq_o));
endmodule

// File: tb/scsi_host_regs_tb.sv
`timescale 1ns/100ps
module scsi_host_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_sel, host_wr, tgt_ack_i;
  logic [5:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       irq_o, tgt_req_o, tgt_op_o;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  scsi_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_o(irq_o), .tgt_req_o(tgt_req_o), .tgt_op_o(tgt_op_o),
    .tgt_ack_i(tgt_ack_i)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [5:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    #1 q = host_rdata;
    @(posedge clk);
    #1 host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic wr_reg(input int i, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b1, 6'(i * 4), d, q);
  endtask

  task automatic rd_reg(input int i, output logic [7:0] q);
    acc(1'b0, 6'(i * 4), 8'h00, q);
  endtask

  task automatic ack_pulse();
    @(negedge clk); tgt_ack_i = 1'b1;
    @(posedge clk); #1 tgt_ack_i = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 29 + seed * 53 + 7) & 8'hff);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0; tgt_ack_i = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, q);
      chk($sformatf("R1 idx%0d", i), q, (i == 14) ? 8'h04 : 8'h00);
    end
    @(negedge clk);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 req", {7'd0, tgt_req_o}, 8'h00);

    // R2 / R3 index decode ignores addr[1:0]
    for (int off = 0; off < 4; off++) begin
      for (int r = 0; r < 2; r++) begin
        logic [7:0] v;
        v = 8'((off * 67 + r * 101 + 13) & 8'hff);
        acc(1'b1, 6'(r * 4 + off), v, q);
        acc(1'b0, 6'(r * 4 + (3 - off)), 8'h00, q);
        chk($sformatf("R2 R3 idx%0d off%0d", r, off), q, v);
      end
    end
    // R3 index-10 mask, all values
    for (int v = 0; v < 256; v++) begin
      wr_reg(10, 8'(v));
      rd_reg(10, q);
      chk($sformatf("R3 mask v=%0d", v), q, 8'(v) & 8'h15);
    end
    wr_reg(8, 8'h55); rd_reg(8, q); chk("R3 idx8 write-only", q, 8'h00);
    wr_reg(9, 8'hA3); rd_reg(9, q); chk("R3 idx9 write-only", q, 8'h00);
    wr_reg(8, 8'h00);

    // R4 short burst
    for (int i = 0; i < 5; i++) wr_reg(2, pat(1, i));
    rd_reg(7, q); chk("R4 level 5", q, 8'd5);
    for (int i = 0; i < 5; i++) begin
      rd_reg(2, q); chk($sformatf("R4 pop%0d", i), q, pat(1, i));
    end
    rd_reg(7, q); chk("R4 level 0", q, 8'd0);
    // R6 drained sets TC
    rd_reg(4, q); chk("R6 tc set", q, 8'h10);

    // R5 overfill
    for (int i = 0; i < 17; i++) wr_reg(2, pat(2, i));
    rd_reg(7, q); chk("R5 level full", q, 8'd16);
    rd_reg(4, q); chk("R5 overflow bit", q, 8'h11);
    for (int i = 0; i < 16; i++) begin
      rd_reg(2, q); chk($sformatf("R5 pop%0d", i), q, pat(2, i));
    end
    rd_reg(2, q); chk("R5 empty pop data", q, 8'h00);
    rd_reg(7, q); chk("R5 empty pop level", q, 8'd0);

    // R10 interrupt read clears status except TC
    rd_reg(5, q); chk("R10 int value", q, 8'h00);
    rd_reg(4, q); chk("R10 status keeps tc", q, 8'h10);

    // R8 unmasked bus reset, R13 request
    wr_reg(3, 8'h03);
    @(negedge clk);
    chk("R8 irq up", {7'd0, irq_o}, 8'h01);
    chk("R13 req up", {7'd0, tgt_req_o}, 8'h01);
    chk("R13 op busrst", {7'd0, tgt_op_o}, 8'h00);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R13 req held", {7'd0, tgt_req_o}, 8'h01);
    ack_pulse();
    @(negedge clk);
    chk("R13 req dropped", {7'd0, tgt_req_o}, 8'h00);
    rd_reg(4, q); chk("R8 status int bit", q, 8'h90);
    rd_reg(5, q); chk("R8 int busrst", q, 8'h80);
    @(negedge clk);
    chk("R10 irq down", {7'd0, irq_o}, 8'h00);
    rd_reg(4, q); chk("R10 status after", q, 8'h10);
    // R8 masked
    wr_reg(8, 8'h40);
    wr_reg(3, 8'h03);
    @(negedge clk);
    chk("R8 masked irq", {7'd0, irq_o}, 8'h00);
    rd_reg(4, q); chk("R8 masked status", q, 8'h10);
    rd_reg(5, q); chk("R8 masked int", q, 8'h80);
    ack_pulse();

    // R9 message accepted
    wr_reg(3, 8'h12);
    @(negedge clk);
    chk("R13 op msgacc", {7'd0, tgt_op_o}, 8'h01);
    chk("R9 irq none", {7'd0, irq_o}, 8'h00);
    rd_reg(5, q); chk("R9 int disc", q, 8'h20);
    ack_pulse();

    // R7 flush
    for (int i = 0; i < 3; i++) wr_reg(2, pat(3, i));
    wr_reg(3, 8'h01);
    rd_reg(7, q); chk("R7 level", q, 8'd0);
    rd_reg(5, q); chk("R7 int done", q, 8'h08);
    rd_reg(2, q); chk("R7 data empty", q, 8'h00);

    // R12 nop and unknown codes
    wr_reg(2, pat(4, 0)); wr_reg(2, pat(4, 1));
    for (int c = 0; c < 4; c++) begin
      logic [7:0] code;
      code = (c == 0) ? 8'h00 : 8'(8'h40 + c * 37);
      wr_reg(3, code);
      rd_reg(3, q); chk($sformatf("R12 echo %h", code), q, code);
      rd_reg(7, q); chk($sformatf("R12 level %h", code), q, 8'd2);
      rd_reg(5, q); chk($sformatf("R12 int %h", code), q, 8'h08);
      @(negedge clk);
      chk($sformatf("R12 irq %h", code), {7'd0, irq_o}, 8'h00);
      chk($sformatf("R12 req %h", code), {7'd0, tgt_req_o}, 8'h00);
    end
    rd_reg(2, q); chk("R12 fifo intact", q, pat(4, 0));

    // R11 chip reset
    wr_reg(0, 8'hAA);
    wr_reg(3, 8'h12);
    wr_reg(3, 8'h02);
    @(negedge clk);
    chk("R11 req cleared", {7'd0, tgt_req_o}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, q);
      chk($sformatf("R11 idx%0d", i), q, (i == 14) ? 8'h04 : 8'h00);
    end
    // mask in write copy 8 was cleared: bus reset now interrupts
    wr_reg(3, 8'h03);
    @(negedge clk);
    chk("R11 R8 mask cleared", {7'd0, irq_o}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule